// File: doc/BRIEF.md
# Receive Bit Low-Time Classifier for a Consumer-Electronics Control Line

This block measures each bit arriving on a single-wire, open-drain consumer-electronics control line and decides what the bit means. A bit begins when the line is seen to fall. From then on, the block counts sample ticks until the line is seen high again. The length of the low phase then gives either a logical 1 (short low), a logical 0 (long low), or a waveform error. The line input is expected to be already synchronized to `clk`. `tick_i` is a one-cycle enable at the sample rate, nominally 32.768 kHz, and all timing is counted in these ticks. At that rate 56 ticks is about 1.709 ms.

Four thresholds mark the boundaries between the classes. Each threshold is a fixed base count plus or minus a 3-bit trim:

| Threshold | Base | Trim |
|-----------|------|------|
| early | 13 | down |
| mid-low | 26 | up |
| mid-high | 43 | down |
| late | 56 | up |

When the check-enable input is low, the thresholds are not used. In that case the block simply splits 1 from 0 at tick 35 and never reports an error. The trims and the check enable are captured only when receive is switched on. This lets software change them safely while reception is off, using `rx_active_o` to confirm that reception has really stopped.

Top module: `cecrx_bit_classifier`

## Requirements
- R1: After reset all result outputs and `rx_active_o` are 0.
- R2: A falling edge is recognized on a tick where `line_i` is 0 and it was 1 on the previous tick. The low time n is the number of ticks from that tick up to the first later tick where `line_i` is 1. Every result appears one `clk` cycle after the tick that ends the bit.
- R3: With checking on, E <= n < ML gives `bit_vld_o`=1 with `bit_val_o`=1. Here E = 13 - early trim and ML = 26 + mid-low trim.
- R4: With checking on, MH <= n < LT gives `bit_vld_o`=1 with `bit_val_o`=0. Here MH = 43 - mid-high trim and LT = 56 + late trim.
- R5: With checking on, n < E pulses `err_short_o` and reports no bit.
- R6: With checking on, ML <= n < MH pulses `err_mid_o` and reports no bit.
- R7: With checking on, if the line is still low, or rises, on the tick where n reaches LT, `err_long_o` pulses on that tick. The block then ignores the line until the next falling edge.
- R8: With checking off, n < 35 gives bit 1 and n >= 35 gives bit 0. No error output is ever raised in this mode.
- R9: The four trims and the check enable are captured on the cycle where `rx_en_i` goes from 0 to 1. Changes to them at any other time have no effect.
- R10: `rx_active_o` equals `rx_en_i` delayed by one cycle. While receive is off there are no results, and a bit that is in progress when receive drops is discarded.
- R11: Every result output is a single-cycle pulse, and at most one of `bit_vld_o`, `err_short_o`, `err_mid_o` and `err_long_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle sample tick enable |
| line_i | input | 1 | Synchronized control-line level |
| rx_en_i | input | 1 | Receive enable |
| chk_en_i | input | 1 | Waveform-check enable (captured on receive enable) |
| adj_early_i | input | ADJ_W | Downward trim of the early threshold |
| adj_midlo_i | input | ADJ_W | Upward trim of the middle window's lower bound |
| adj_midhi_i | input | ADJ_W | Downward trim of the middle window's upper bound |
| adj_late_i | input | ADJ_W | Upward trim of the late threshold |
| bit_vld_o | output | 1 | Pulse: a valid bit was decoded |
| bit_val_o | output | 1 | Decoded bit value, valid with `bit_vld_o` |
| err_short_o | output | 1 | Pulse: low phase shorter than the early threshold |
| err_mid_o | output | 1 | Pulse: rising edge inside the forbidden middle window |
| err_long_o | output | 1 | Pulse: low phase reached the late threshold |
| rx_active_o | output | 1 | Reception is running (registered receive enable) |

## Verification
The bench builds the block with its default parameters: an 8-bit tick counter, bases of 13, 26, 43 and 56, a split point of 35, and 3-bit trims. Both trim extremes, 0 and 7, can therefore be applied to every threshold. Each boundary is tested one tick on either side: 6 and 13 for the early threshold, 26 and 33 for mid-low, 36 and 43 for mid-high, and 56 and 63 for late. With checking off, the bench holds the line low for 80 ticks. This is well under the counter's saturation point, so it confirms that an unchecked long bit still decodes as 0 without raising an error.

// File: rtl/cecrx_pkg.sv
package cecrx_pkg;

    // Threshold slots, in the order the trim vector is packed
    localparam int NUM_THR   = 4;
    localparam int THR_EARLY = 0;
    localparam int THR_MIDLO = 1;
    localparam int THR_MIDHI = 2;
    localparam int THR_LATE  = 3;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_LOW  = 1'b1
    } cecrx_st_e;

    // A threshold moves up when its trim widens the window it guards on the high side
    function automatic bit thr_raises(input int idx);
        return (idx == THR_MIDLO) || (idx == THR_LATE);
    endfunction

endpackage

// File: rtl/cecrx_cfg.sv
module cecrx_cfg
    import cecrx_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int ADJ_W      = 3,
    parameter int EARLY_BASE = 13,
    parameter int MIDLO_BASE = 26,
    parameter int MIDHI_BASE = 43,
    parameter int LATE_BASE  = 56
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rx_en_i,
    input  logic                     chk_en_i,
    input  logic [NUM_THR*ADJ_W-1:0] adj_i,
    output logic                     en_o,
    output logic                     chk_o,
    output logic [NUM_THR*CNT_W-1:0] thr_o
);

    localparam int ADJ_TOT = NUM_THR * ADJ_W;

    typedef struct packed {
        logic               en;
        logic               chk;
        logic [ADJ_TOT-1:0] adj;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d    = cfg_q;
        cfg_d.en = rx_en_i;
        // capture settings only on the rising edge of receive enable
        if (rx_en_i && !cfg_q.en) begin
            cfg_d.chk = chk_en_i;
            cfg_d.adj = adj_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign en_o  = cfg_q.en;
    assign chk_o = cfg_q.chk;

    for (genvar i = 0; i < NUM_THR; i++) begin : g_thr
        localparam int BASE = (i == THR_EARLY) ? EARLY_BASE :
                              (i == THR_MIDLO) ? MIDLO_BASE :
                              (i == THR_MIDHI) ? MIDHI_BASE : LATE_BASE;
        logic [CNT_W-1:0] trim;
        assign trim = CNT_W'(cfg_q.adj[i*ADJ_W +: ADJ_W]);
        if (thr_raises(i)) begin : g_up
            assign thr_o[i*CNT_W +: CNT_W] = CNT_W'(BASE) + trim;
        end else begin : g_dn
            assign thr_o[i*CNT_W +: CNT_W] = CNT_W'(BASE) - trim;
        end
    end

endmodule

// File: rtl/cecrx_edge.sv
module cecrx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic line_i,
    output logic fall_o
);

    typedef struct packed {
        logic line;
    } edge_t;

    edge_t edge_d, edge_q;

    always_comb begin
        edge_d = edge_q;
        if (tick_i) begin
            edge_d.line = line_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q.line <= 1'b1; // idle bus is high
        end else begin
            edge_q <= edge_d;
        end
    end

    assign fall_o = tick_i && edge_q.line && !line_i;

endmodule

// File: rtl/cecrx_classify.sv
module cecrx_classify
    import cecrx_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int SPLIT = 35
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             line_i,
    input  logic             fall_i,
    input  logic             run_i,
    input  logic             chk_i,
    input  logic [CNT_W-1:0] thr_early_i,
    input  logic [CNT_W-1:0] thr_midlo_i,
    input  logic [CNT_W-1:0] thr_midhi_i,
    input  logic [CNT_W-1:0] thr_late_i,
    output logic             bit_vld_o,
    output logic             bit_val_o,
    output logic             err_short_o,
    output logic             err_mid_o,
    output logic             err_long_o
);

    localparam logic [CNT_W-1:0] SPLIT_CNT = CNT_W'(SPLIT);

    typedef struct packed {
        cecrx_st_e        st;
        logic [CNT_W-1:0] cnt;
        logic             vld;
        logic             val;
        logic             e_short;
        logic             e_mid;
        logic             e_long;
    } cls_t;

    cls_t cls_d, cls_q;
    logic [CNT_W-1:0] n_c;

    always_comb begin
        cls_d         = cls_q;
        cls_d.vld     = 1'b0;
        cls_d.e_short = 1'b0;
        cls_d.e_mid   = 1'b0;
        cls_d.e_long  = 1'b0;
        // saturating low-time count including the current tick
        n_c = (&cls_q.cnt) ? cls_q.cnt : cls_q.cnt + 1'b1;

        if (!run_i) begin
            cls_d.st  = ST_IDLE;
            cls_d.cnt = '0;
        end else begin
            unique case (cls_q.st)
                ST_IDLE: begin
                    if (fall_i) begin
                        cls_d.st  = ST_LOW;
                        cls_d.cnt = '0;
                    end
                end
                ST_LOW: begin
                    if (tick_i) begin
                        cls_d.cnt = n_c;
                        if (chk_i && (n_c >= thr_late_i)) begin
                            cls_d.e_long = 1'b1;
                            cls_d.st     = ST_IDLE;
                        end else if (line_i) begin
                            cls_d.st = ST_IDLE;
                            if (!chk_i) begin
                                cls_d.vld = 1'b1;
                                cls_d.val = (n_c < SPLIT_CNT);
                            end else if (n_c < thr_early_i) begin
                                cls_d.e_short = 1'b1;
                            end else if (n_c < thr_midlo_i) begin
                                cls_d.vld = 1'b1;
                                cls_d.val = 1'b1;
                            end else if (n_c < thr_midhi_i) begin
                                cls_d.e_mid = 1'b1;
                            end else begin
                                cls_d.vld = 1'b1;
                                cls_d.val = 1'b0;
                            end
                        end
                    end
                end
                default: cls_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cls_q <= '{st: ST_IDLE, cnt: '0, vld: 1'b0, val: 1'b0,
                       e_short: 1'b0, e_mid: 1'b0, e_long: 1'b0};
        end else begin
            cls_q <= cls_d;
        end
    end

    assign bit_vld_o   = cls_q.vld;
    assign bit_val_o   = cls_q.val;
    assign err_short_o = cls_q.e_short;
    assign err_mid_o   = cls_q.e_mid;
    assign err_long_o  = cls_q.e_long;

endmodule

// File: rtl/cecrx_bit_classifier.sv
module cecrx_bit_classifier
    import cecrx_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int ADJ_W      = 3,
    parameter int EARLY_BASE = 13,
    parameter int MIDLO_BASE = 26,
    parameter int MIDHI_BASE = 43,
    parameter int LATE_BASE  = 56,
    parameter int SPLIT      = 35
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             line_i,
    input  logic             rx_en_i,
    input  logic             chk_en_i,
    input  logic [ADJ_W-1:0] adj_early_i,
    input  logic [ADJ_W-1:0] adj_midlo_i,
    input  logic [ADJ_W-1:0] adj_midhi_i,
    input  logic [ADJ_W-1:0] adj_late_i,
    output logic             bit_vld_o,
    output logic             bit_val_o,
    output logic             err_short_o,
    output logic             err_mid_o,
    output logic             err_long_o,
    output logic             rx_active_o
);

    logic [NUM_THR*ADJ_W-1:0] adj_all;
    logic [NUM_THR*CNT_W-1:0] thr_all;
    logic                     en_q;
    logic                     chk_q;
    logic                     fall;
    logic                     run;

    assign adj_all = {adj_late_i, adj_midhi_i, adj_midlo_i, adj_early_i};

    cecrx_cfg #(
        .CNT_W     (CNT_W),
        .ADJ_W     (ADJ_W),
        .EARLY_BASE(EARLY_BASE),
        .MIDLO_BASE(MIDLO_BASE),
        .MIDHI_BASE(MIDHI_BASE),
        .LATE_BASE (LATE_BASE)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_en_i (rx_en_i),
        .chk_en_i(chk_en_i),
        .adj_i   (adj_all),
        .en_o    (en_q),
        .chk_o   (chk_q),
        .thr_o   (thr_all)
    );

    cecrx_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .tick_i(tick_i),
        .line_i(line_i),
        .fall_o(fall)
    );

    // results only while receive is on now and was on when settings were captured
    assign run = rx_en_i && en_q;

    cecrx_classify #(
        .CNT_W(CNT_W),
        .SPLIT(SPLIT)
    ) u_classify (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .line_i     (line_i),
        .fall_i     (fall),
        .run_i      (run),
        .chk_i      (chk_q),
        .thr_early_i(thr_all[THR_EARLY*CNT_W +: CNT_W]),
        .thr_midlo_i(thr_all[THR_MIDLO*CNT_W +: CNT_W]),
        .thr_midhi_i(thr_all[THR_MIDHI*CNT_W +: CNT_W]),
        .thr_late_i (thr_all[THR_LATE*CNT_W +: CNT_W]),
        .bit_vld_o  (bit_vld_o),
        .bit_val_o  (bit_val_o),
        .err_short_o(err_short_o),
        .err_mid_o  (err_mid_o),
        .err_long_o (err_long_o)
    );

    assign rx_active_o = en_q;

endmodule

// File: rtl/cecrx_bit_classifier_chk.sv
module cecrx_bit_classifier_chk (
    input logic clk,
    input logic rst_n,
    input logic tick_i,
    input logic rx_en_i,
    input logic bit_vld_o,
    input logic err_short_o,
    input logic err_mid_o,
    input logic err_long_o,
    input logic rx_active_o
);

    logic past_ok;
    logic any_res;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    assign any_res = bit_vld_o || err_short_o || err_mid_o || err_long_o;

    assert_one_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bit_vld_o, err_short_o, err_mid_o, err_long_o}));

    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        any_res |=> !any_res);

    assert_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && any_res) |-> $past(tick_i));

    assert_active_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (rx_active_o == $past(rx_en_i)));

    assert_quiet_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_active_o |-> !any_res);

endmodule

bind cecrx_bit_classifier cecrx_bit_classifier_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .rx_en_i    (rx_en_i),
    .bit_vld_o  (bit_vld_o),
    .err_short_o(err_short_o),
    .err_mid_o  (err_mid_o),
    .err_long_o (err_long_o),
    .rx_active_o(rx_active_o)
);

// File: tb/cecrx_bit_classifier_bench.sv
module cecrx_bit_classifier_bench;

    // result codes: 0 none, 1 bit one, 2 bit zero, 3 short, 4 mid, 5 long, 7 several
    typedef struct packed {
        logic       chk;
        logic [2:0] a_early;
        logic [2:0] a_midlo;
        logic [2:0] a_midhi;
        logic [2:0] a_late;
        logic [7:0] len;
        logic [2:0] code;
    } vec_t;

    localparam int NVEC = 28;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 3'd0, 3'd0, 3'd0, 3'd0, 8'd13, 3'd1},  // R3 lower edge
        '{1'b1, 3'd0, 3'd0, 3'd0, 3'd0, 8'd12, 3'd3},  // R5
        '{1'b1, 3'd0, 3'd0, 3'd0, 3'd0, 8'd1,  3'd3},  // R5 minimum
        '{1'b1, 3'd0, 3'd0, 3'd0, 3'd0, 8'd25, 3'd1},  // R3 upper edge
        '{1'b1, 3'd0, 3'd0, 3'd0, 3'd0, 8'd26, 3'd4},  // R6
        '{1'b1, 3'd0, 3'd0, 3'd0, 3'd0, 8'd42, 3'd4},  // R6
        '{1'b1, 3'd0, 3'd0, 3'd0, 3'd0, 8'd43, 3'd2},  // R4
        '{1'b1, 3'd0, 3'd0, 3'd0, 3'd0, 8'd55, 3'd2},  // R4
        '{1'b1, 3'd0, 3'd0, 3'd0, 3'd0, 8'd56, 3'd5},  // R7 rise on LT
        '{1'b1, 3'd0, 3'd0, 3'd0, 3'd0, 8'd70, 3'd5},  // R7 stuck low
        '{1'b1, 3'd7, 3'd0, 3'd0, 3'd0, 8'd6,  3'd1},  // R3 trimmed E=6
        '{1'b1, 3'd7, 3'd0, 3'd0, 3'd0, 8'd5,  3'd3},  // R5
        '{1'b1, 3'd0, 3'd7, 3'd0, 3'd0, 8'd32, 3'd1},  // R3 ML=33
        '{1'b1, 3'd0, 3'd7, 3'd0, 3'd0, 8'd33, 3'd4},  // R6
        '{1'b1, 3'd0, 3'd0, 3'd7, 3'd0, 8'd35, 3'd4},  // R6 MH=36
        '{1'b1, 3'd0, 3'd0, 3'd7, 3'd0, 8'd36, 3'd2},  // R4
        '{1'b1, 3'd0, 3'd0, 3'd0, 3'd7, 8'd62, 3'd2},  // R4 LT=63
        '{1'b1, 3'd0, 3'd0, 3'd0, 3'd7, 8'd63, 3'd5},  // R7
        '{1'b1, 3'd7, 3'd7, 3'd7, 3'd7, 8'd33, 3'd4},  // R6 narrow window
        '{1'b1, 3'd7, 3'd7, 3'd7, 3'd7, 8'd35, 3'd4},  // R6
        '{1'b1, 3'd7, 3'd7, 3'd7, 3'd7, 8'd36, 3'd2},  // R4
        '{1'b1, 3'd7, 3'd7, 3'd7, 3'd7, 8'd8,  3'd1},  // R3
        '{1'b0, 3'd0, 3'd0, 3'd0, 3'd0, 8'd3,  3'd1},  // R8
        '{1'b0, 3'd0, 3'd0, 3'd0, 3'd0, 8'd30, 3'd1},  // R8 inside mid window
        '{1'b0, 3'd0, 3'd0, 3'd0, 3'd0, 8'd34, 3'd1},  // R8 split edge
        '{1'b0, 3'd0, 3'd0, 3'd0, 3'd0, 8'd35, 3'd2},  // R8
        '{1'b0, 3'd7, 3'd7, 3'd7, 3'd7, 8'd12, 3'd1},  // R8 trims unused
        '{1'b0, 3'd0, 3'd0, 3'd0, 3'd0, 8'd80, 3'd2}   // R8 no long error
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       line = 1'b1;
    logic       rx_en = 1'b0;
    logic       chk_en = 1'b0;
    logic [2:0] adj_e = '0, adj_ml = '0, adj_mh = '0, adj_l = '0;
    logic       bit_vld, bit_val, err_s, err_m, err_l, rx_act;

    int n_checks = 0;
    int n_fail   = 0;
    int c_one, c_zero, c_short, c_mid, c_long;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cecrx_bit_classifier u_cecrx_bit_classifier (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .line_i     (line),
        .rx_en_i    (rx_en),
        .chk_en_i   (chk_en),
        .adj_early_i(adj_e),
        .adj_midlo_i(adj_ml),
        .adj_midhi_i(adj_mh),
        .adj_late_i (adj_l),
        .bit_vld_o  (bit_vld),
        .bit_val_o  (bit_val),
        .err_short_o(err_s),
        .err_mid_o  (err_m),
        .err_long_o (err_l),
        .rx_active_o(rx_act)
    );

    task automatic check(input string req, input int got, input int exp, input string what);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic clear_counts();
        c_one = 0; c_zero = 0; c_short = 0; c_mid = 0; c_long = 0;
    endtask

    // sample outputs at a falling edge and tally any result pulse
    task automatic tally();
        if (bit_vld && bit_val)  c_one++;
        if (bit_vld && !bit_val) c_zero++;
        if (err_s) c_short++;
        if (err_m) c_mid++;
        if (err_l) c_long++;
    endtask

    task automatic tick_once();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        tally();
        @(negedge clk) tally();
    endtask

    function automatic int result_code();
        int tot = c_one + c_zero + c_short + c_mid + c_long;
        if (tot == 0) return 0;
        if (tot > 1)  return 7;
        if (c_one == 1)   return 1;
        if (c_zero == 1)  return 2;
        if (c_short == 1) return 3;
        if (c_mid == 1)   return 4;
        return 5;
    endfunction

    function automatic string code_req(input int code, input bit chk);
        if (!chk) return "R8";
        case (code)
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic set_cfg(input bit chk, input logic [2:0] e, input logic [2:0] ml,
                           input logic [2:0] mh, input logic [2:0] l);
        @(negedge clk) rx_en = 1'b0;
        @(negedge clk);
        chk_en = chk; adj_e = e; adj_ml = ml; adj_mh = mh; adj_l = l;
        @(negedge clk) rx_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    // low phase of len ticks, then two idle ticks; tallies every pulse seen
    task automatic send_bit(input int len);
        clear_counts();
        line = 1'b0;
        tick_once();
        for (int j = 1; j <= len; j++) begin
            if (j == len) line = 1'b1;
            tick_once();
        end
        tick_once();
        tick_once();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1", int'(bit_vld), 0, "bit_vld in reset");
        check("R1", int'(rx_act), 0, "rx_active in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'({err_s, err_m, err_l}), 0, "errors after reset");
        check("R1", int'(rx_act), 0, "rx_active after reset");

        // R10: active follows enable by one cycle
        @(negedge clk) rx_en = 1'b1;
        check("R10", int'(rx_act), 0, "rx_active same cycle");
        @(negedge clk);
        check("R10", int'(rx_act), 1, "rx_active one cycle later");

        // table walk (R2 through R8)
        for (int v = 0; v < NVEC; v++) begin
            set_cfg(VECS[v].chk, VECS[v].a_early, VECS[v].a_midlo, VECS[v].a_midhi, VECS[v].a_late);
            send_bit(int'(VECS[v].len));
            check(code_req(int'(VECS[v].code), VECS[v].chk), result_code(), int'(VECS[v].code),
                  $sformatf("vector %0d len %0d", v, VECS[v].len));
        end

        // R2: two bits back to back share no state
        set_cfg(1'b1, 3'd0, 3'd0, 3'd0, 3'd0);
        send_bit(20);
        check("R2", result_code(), 1, "first of pair");
        send_bit(50);
        check("R2", result_code(), 2, "second of pair");

        // R9: trims changed while receiving are ignored
        set_cfg(1'b1, 3'd0, 3'd0, 3'd0, 3'd0);
        adj_e = 3'd7;
        chk_en = 1'b0;
        send_bit(8);
        check("R9", result_code(), 3, "live early trim ignored");
        send_bit(30);
        check("R9", result_code(), 4, "live check disable ignored");

        // R10: nothing reported while receive is off
        @(negedge clk) rx_en = 1'b0;
        @(negedge clk);
        check("R10", int'(rx_act), 0, "rx_active after disable");
        send_bit(20);
        check("R10", result_code(), 0, "bit while disabled");

        // R10: bit in progress dropped when receive goes off
        set_cfg(1'b1, 3'd0, 3'd0, 3'd0, 3'd0);
        clear_counts();
        line = 1'b0;
        tick_once();
        for (int j = 0; j < 5; j++) tick_once();
        @(negedge clk) rx_en = 1'b0;
        @(negedge clk) rx_en = 1'b1;
        @(negedge clk);
        for (int j = 0; j < 14; j++) tick_once();
        line = 1'b1;
        tick_once();
        tick_once();
        check("R10", result_code(), 0, "aborted bit discarded");

        // R7: after a long error the line is ignored until the next fall
        send_bit(60);
        check("R7", result_code(), 5, "long then idle");
        send_bit(15);
        check("R7", result_code(), 1, "next bit after long error");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule